// File: doc/BRIEF.md
# Slot-Based Packet Buffer Controller

This block sits between a network MAC and a host processor and moves whole frames through a shared on-chip memory. The memory is split into numbered slots of fixed size. Receive slots start at word zero. Transmit slots follow them, starting at byte offset rx_slots times slot_size.

On the receive side, bytes arrive from the MAC as single-cycle beats, with a marker on the last byte of each frame. A writer engine stores each frame in the lowest free receive slot. It then announces the frame through a pending event, together with the slot number and the stored length. Completed frames queue in arrival order. The host drains them one at a time by writing one to the pending register, which also returns that slot to the free pool.

On the transmit side, the host fills a transmit slot through the buffer port, checks the ready flag, loads a slot number and a length, and writes the start register. A reader engine then streams those bytes to the MAC with valid/ready flow control. When it finishes, it raises its own pending event. Each pending event can drive the interrupt output through its own enable bit.

Top module: `slot_pktbuf`

## Requirements
- R1: After reset, both pending events read 0, the interrupt is low, reader ready (0x1C) reads 1, reader level (0x20) reads 0, the drop counter (0x08) reads 0, and tx_valid is low.
- R2: A received frame of N bytes lands in the lowest free receive slot. Writer pending (0x10, bit 0) becomes 1 on the clock edge that takes the last byte. Writer slot (0x00) reports the slot. Writer length (0x04) reports min(N, SLOT_BYTES). Byte i of the frame is held in buffer word slot*SLOT_BYTES/4 + i/4, in byte lane i%4, where lane 0 is bits 7:0. Unused lanes of the final partial word read 0. Bytes beyond SLOT_BYTES are discarded.
- R3: Frames completed while an earlier one is still pending are queued in arrival order. After each clear, the next frame's slot and length are presented at once.
- R4: Writing 1 to bit 0 of writer pending removes the presented frame and frees its slot. Writing 0 there changes nothing.
- R5: A frame that starts while no receive slot is free is not stored. It increments the drop counter, which saturates at its all-ones value. The presented slot, length and pending state stay unchanged.
- R6: After a start, the reader sends min(L, SLOT_BYTES) bytes from transmit slot S, where S is the reader slot register (0x24) and L is the reader length register (0x28). Byte i comes from buffer word RX_SLOTS*SLOT_BYTES/4 + S*SLOT_BYTES/4 + i/4, lane i%4. tx_last is asserted on the final byte only. tx_data and tx_last hold while tx_ready is low. A length of 0 sends no bytes but still completes.
- R7: Reader ready reads 0 while a frame is being sent or while the command queue is full. A start written while ready is 0 is ignored: no command is queued and no extra frame is sent.
- R8: When the reader finishes a frame, reader pending (0x30, bit 0) becomes 1. Writing 1 there clears it.
- R9: The interrupt is the OR of writer pending AND writer enable (0x14, bit 0) with reader pending AND reader enable (0x34, bit 0).
- R10: Reader level (0x20) reports how many start commands are queued and not yet taken by the reader engine. A command accepted on one edge is counted until the engine takes it on the next edge when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte ends its frame |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends its frame |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr (combinational) |
| buf_we | input | 1 | Buffer word write strobe |
| buf_addr | input | AW | Buffer word index |
| buf_wdata | input | 32 | Buffer write word |
| buf_rdata | output | 32 | Buffer word at buf_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong slot-occupancy bit can show up in two ways. It may put a later frame in the wrong slot, which is visible in the slot register on the edge that ends that frame. Or it may drop a frame that should have fit, which the drop counter exposes at once. A broken receive queue presents the wrong slot or length right after a clear, on the very next register read. Errors in the reader's byte index or base address appear as wrong bytes in the transmit stream within one slot's worth of cycles. A lost done pulse leaves reader pending low, so the polling loop runs out.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  // Register byte offsets decoded by host software
  localparam logic [7:0] REG_RX_SLOT  = 8'h00;
  localparam logic [7:0] REG_RX_LEN   = 8'h04;
  localparam logic [7:0] REG_RX_DROPS = 8'h08;
  localparam logic [7:0] REG_RX_STAT  = 8'h0C;
  localparam logic [7:0] REG_RX_PEND  = 8'h10;
  localparam logic [7:0] REG_RX_IEN   = 8'h14;
  localparam logic [7:0] REG_TX_GO    = 8'h18;
  localparam logic [7:0] REG_TX_RDY   = 8'h1C;
  localparam logic [7:0] REG_TX_LVL   = 8'h20;
  localparam logic [7:0] REG_TX_SLOT  = 8'h24;
  localparam logic [7:0] REG_TX_LEN   = 8'h28;
  localparam logic [7:0] REG_TX_STAT  = 8'h2C;
  localparam logic [7:0] REG_TX_PEND  = 8'h30;
  localparam logic [7:0] REG_TX_IEN   = 8'h34;

  // Place one byte into lane 0..3 of a 32-bit word
  function automatic logic [31:0] put_lane(input logic [31:0] word,
                                           input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = word;
    r[lane*8 +: 8] = b;
    return r;
  endfunction

  // Pick one byte out of a 32-bit word
  function automatic logic [7:0] get_lane(input logic [31:0] word,
                                          input logic [1:0] lane);
    return word[lane*8 +: 8];
  endfunction
endpackage

// File: rtl/pktbuf_fifo.sv
module pktbuf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rd_ptr];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) begin
        store[wr_ptr] <= din;
        wr_ptr        <= step(wr_ptr);
      end
      if (do_pop) rd_ptr <= step(rd_ptr);
      if (do_push && !do_pop) cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  // R3
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R10
  fifo_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count != '0));
endmodule

// File: rtl/pktbuf_rx_writer.sv
module pktbuf_rx_writer
  import pktbuf_pkg::*;
#(
  parameter int RX_SLOTS   = 2,
  parameter int SLOT_BYTES = 2048,
  parameter int AW         = 11,
  parameter int ERR_W      = 32,
  localparam int SW        = (RX_SLOTS > 1) ? $clog2(RX_SLOTS) : 1,
  localparam int LW        = $clog2(SLOT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             release_i,
  output logic [SW-1:0]    head_slot,
  output logic [LW-1:0]    head_len,
  output logic             pending,
  output logic [ERR_W-1:0] drops,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata
);
  localparam int WPS = SLOT_BYTES / 4;

  logic [RX_SLOTS-1:0] used_q;
  logic                in_frame_q, drop_q;
  logic [SW-1:0]       slot_q;
  logic [LW-1:0]       idx_q;
  logic [31:0]         acc_q;
  logic [ERR_W-1:0]    err_q;

  // Named events for assertions
  logic          first_beat, have_free, accept, in_slot, frame_push, overflow_drop, release_do;
  logic [SW-1:0] cur_slot;
  logic [LW-1:0] cur_idx, push_len;
  logic [31:0]   merged;
  logic          q_empty, q_full;
  logic [$clog2(RX_SLOTS+1)-1:0] q_count;

  function automatic logic [SW-1:0] lowest_free(input logic [RX_SLOTS-1:0] used);
    logic [SW-1:0] r;
    r = '0;
    for (int s = RX_SLOTS - 1; s >= 0; s--) if (!used[s]) r = SW'(s);
    return r;
  endfunction

  function automatic logic [AW-1:0] word_addr(input logic [SW-1:0] slot,
                                              input logic [LW-1:0] idx);
    return AW'(int'(slot) * WPS + int'(idx >> 2));
  endfunction

  assign first_beat    = rx_valid && !in_frame_q;
  assign have_free     = |(~used_q);
  assign accept        = rx_valid && (first_beat ? have_free : !drop_q);
  assign cur_slot      = first_beat ? lowest_free(used_q) : slot_q;
  assign cur_idx       = first_beat ? '0 : idx_q;
  assign in_slot       = (cur_idx < LW'(SLOT_BYTES));
  assign merged        = put_lane(first_beat ? 32'd0 : acc_q, cur_idx[1:0], rx_data);
  assign mem_we        = accept && in_slot && ((cur_idx[1:0] == 2'd3) || rx_last);
  assign mem_addr      = word_addr(cur_slot, cur_idx);
  assign mem_wdata     = merged;
  assign frame_push    = accept && rx_last;
  assign push_len      = in_slot ? cur_idx + LW'(1) : LW'(SLOT_BYTES);
  assign overflow_drop = first_beat && !have_free;
  assign release_do    = release_i && !q_empty;
  assign pending       = !q_empty;
  assign drops         = err_q;

  pktbuf_fifo #(.W(SW + LW), .DEPTH(RX_SLOTS)) u_doneq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (frame_push),
    .din   ({cur_slot, push_len}),
    .pop   (release_do),
    .dout  ({head_slot, head_len}),
    .count (q_count),
    .full  (q_full),
    .empty (q_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q     <= '0;
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      slot_q     <= '0;
      idx_q      <= '0;
      acc_q      <= '0;
      err_q      <= '0;
    end else begin
      if (rx_valid) in_frame_q <= !rx_last;
      if (first_beat) begin
        drop_q <= !have_free;
        slot_q <= cur_slot;
      end
      if (accept) begin
        idx_q <= in_slot ? cur_idx + LW'(1) : cur_idx;
        acc_q <= mem_we ? 32'd0 : merged;
      end
      if (release_do) used_q[head_slot] <= 1'b0;
      if (first_beat && have_free) used_q[cur_slot] <= 1'b1;
      if (overflow_drop && (err_q != '1)) err_q <= err_q + ERR_W'(1);
    end
  end

  // R5
  drops_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drops >= $past(drops)));
  // R2
  push_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_push |-> (rx_valid && rx_last && !q_full));
  // R5
  drop_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_drop && !release_i) |=> pending);
  // R2
  len_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (head_len != '0 && head_len <= LW'(SLOT_BYTES)));
endmodule

// File: rtl/pktbuf_tx_reader.sv
module pktbuf_tx_reader
  import pktbuf_pkg::*;
#(
  parameter int RX_SLOTS   = 2,
  parameter int TX_SLOTS   = 2,
  parameter int SLOT_BYTES = 2048,
  parameter int TXQ_DEPTH  = 2,
  parameter int AW         = 11,
  localparam int TSW       = (TX_SLOTS > 1) ? $clog2(TX_SLOTS) : 1,
  localparam int LW        = $clog2(SLOT_BYTES + 1),
  localparam int QCW       = $clog2(TXQ_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_push,
  input  logic [TSW-1:0] cmd_slot,
  input  logic [31:0]    cmd_len,
  output logic           ready,
  output logic           idle,
  output logic [QCW-1:0] level,
  output logic [AW-1:0]  rd_addr,
  input  logic [31:0]    rd_word,
  output logic           tx_valid,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  input  logic           tx_ready,
  output logic           done
);
  localparam int WPS = SLOT_BYTES / 4;

  logic           busy_q;
  logic [TSW-1:0] slot_q;
  logic [LW-1:0]  len_q, idx_q;
  logic [TSW-1:0] q_slot;
  logic [LW-1:0]  q_len;
  logic           q_full, q_empty, take, fire;

  function automatic logic [LW-1:0] cap_len(input logic [31:0] len);
    return (len > 32'(SLOT_BYTES)) ? LW'(SLOT_BYTES) : LW'(len);
  endfunction

  function automatic logic [AW-1:0] tx_addr(input logic [TSW-1:0] slot,
                                            input logic [LW-1:0] idx);
    return AW'(RX_SLOTS * WPS + (int'(slot) % TX_SLOTS) * WPS + int'(idx >> 2));
  endfunction

  pktbuf_fifo #(.W(TSW + LW), .DEPTH(TXQ_DEPTH)) u_cmdq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_push),
    .din   ({cmd_slot, cap_len(cmd_len)}),
    .pop   (take),
    .dout  ({q_slot, q_len}),
    .count (level),
    .full  (q_full),
    .empty (q_empty)
  );

  assign take     = !busy_q && !q_empty;
  assign ready    = !busy_q && !q_full;
  assign idle     = !busy_q && q_empty;
  assign rd_addr  = tx_addr(slot_q, idx_q);
  assign tx_valid = busy_q && (len_q != '0);
  assign tx_data  = get_lane(rd_word, idx_q[1:0]);
  assign tx_last  = tx_valid && (idx_q == len_q - LW'(1));
  assign fire     = tx_valid && tx_ready;
  assign done     = busy_q && ((len_q == '0) || (fire && tx_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      slot_q <= q_slot;
      len_q  <= q_len;
      idx_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (fire) begin
      idx_q <= idx_q + LW'(1);
    end
  end

  // R7
  done_ends_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !tx_valid);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R7
  push_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> !busy_q);
endmodule

// File: rtl/slot_pktbuf.sv
module slot_pktbuf
  import pktbuf_pkg::*;
#(
  parameter int RX_SLOTS   = 2,
  parameter int TX_SLOTS   = 2,
  parameter int SLOT_BYTES = 2048,
  parameter int TXQ_DEPTH  = 2,
  parameter int ERR_W      = 32,
  localparam int WPS       = SLOT_BYTES / 4,
  localparam int MEM_WORDS = (RX_SLOTS + TX_SLOTS) * WPS,
  localparam int AW        = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          csr_we,
  input  logic [7:0]    csr_addr,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [31:0]   buf_wdata,
  output logic [31:0]   buf_rdata,
  output logic          irq
);
  localparam int SW  = (RX_SLOTS > 1) ? $clog2(RX_SLOTS) : 1;
  localparam int TSW = (TX_SLOTS > 1) ? $clog2(TX_SLOTS) : 1;
  localparam int LW  = $clog2(SLOT_BYTES + 1);
  localparam int QCW = $clog2(TXQ_DEPTH + 1);

  logic [31:0] mem [MEM_WORDS];

  logic [SW-1:0]    rx_head_slot;
  logic [LW-1:0]    rx_head_len;
  logic             rx_pend;
  logic [ERR_W-1:0] rx_drops;
  logic             wr_we;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [31:0]      wr_wdata, rd_word;
  logic             tx_rdy, tx_idle, tx_done;
  logic [QCW-1:0]   tx_level;

  logic           rx_ien_q, tx_ien_q, tx_pend_q;
  logic [TSW-1:0] tx_slot_q;
  logic [31:0]    tx_len_q;

  // Named host events
  logic rx_clear, tx_clear, start_req, cmd_push;
  assign rx_clear  = csr_we && (csr_addr == REG_RX_PEND) && csr_wdata[0];
  assign tx_clear  = csr_we && (csr_addr == REG_TX_PEND) && csr_wdata[0];
  assign start_req = csr_we && (csr_addr == REG_TX_GO) && csr_wdata[0];
  assign cmd_push  = start_req && tx_rdy;

  always_ff @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
    if (wr_we)  mem[wr_addr]  <= wr_wdata;
  end
  assign buf_rdata = mem[buf_addr];
  assign rd_word   = mem[rd_addr];

  pktbuf_rx_writer #(.RX_SLOTS(RX_SLOTS), .SLOT_BYTES(SLOT_BYTES), .AW(AW), .ERR_W(ERR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .release_i (rx_clear),
    .head_slot (rx_head_slot),
    .head_len  (rx_head_len),
    .pending   (rx_pend),
    .drops     (rx_drops),
    .mem_we    (wr_we),
    .mem_addr  (wr_addr),
    .mem_wdata (wr_wdata)
  );

  pktbuf_tx_reader #(.RX_SLOTS(RX_SLOTS), .TX_SLOTS(TX_SLOTS), .SLOT_BYTES(SLOT_BYTES),
                     .TXQ_DEPTH(TXQ_DEPTH), .AW(AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_push (cmd_push),
    .cmd_slot (tx_slot_q),
    .cmd_len  (tx_len_q),
    .ready    (tx_rdy),
    .idle     (tx_idle),
    .level    (tx_level),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .done     (tx_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ien_q  <= 1'b0;
      tx_ien_q  <= 1'b0;
      tx_pend_q <= 1'b0;
      tx_slot_q <= '0;
      tx_len_q  <= '0;
    end else begin
      if (csr_we) begin
        case (csr_addr)
          REG_RX_IEN:  rx_ien_q  <= csr_wdata[0];
          REG_TX_IEN:  tx_ien_q  <= csr_wdata[0];
          REG_TX_SLOT: tx_slot_q <= csr_wdata[TSW-1:0];
          REG_TX_LEN:  tx_len_q  <= csr_wdata;
          default: ;
        endcase
      end
      if (tx_done) tx_pend_q <= 1'b1;
      else if (tx_clear) tx_pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (csr_addr)
      REG_RX_SLOT:  csr_rdata = 32'(rx_head_slot);
      REG_RX_LEN:   csr_rdata = 32'(rx_head_len);
      REG_RX_DROPS: csr_rdata = 32'(rx_drops);
      REG_RX_STAT:  csr_rdata = {31'd0, rx_pend};
      REG_RX_PEND:  csr_rdata = {31'd0, rx_pend};
      REG_RX_IEN:   csr_rdata = {31'd0, rx_ien_q};
      REG_TX_RDY:   csr_rdata = {31'd0, tx_rdy};
      REG_TX_LVL:   csr_rdata = 32'(tx_level);
      REG_TX_SLOT:  csr_rdata = 32'(tx_slot_q);
      REG_TX_LEN:   csr_rdata = tx_len_q;
      REG_TX_STAT:  csr_rdata = {31'd0, tx_idle};
      REG_TX_PEND:  csr_rdata = {31'd0, tx_pend_q};
      REG_TX_IEN:   csr_rdata = {31'd0, tx_ien_q};
      default:      csr_rdata = 32'd0;
    endcase
  end

  assign irq = (rx_pend && rx_ien_q) || (tx_pend_q && tx_ien_q);

  // R8
  tx_pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pend_q) |-> $past(tx_done));
  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ien_q || tx_ien_q));
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !tx_rdy) |=> (tx_level <= $past(tx_level)));
  // R4
  rx_clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (csr_addr == REG_RX_PEND) && !csr_wdata[0] && rx_pend) |=> rx_pend);
endmodule

// File: tb/sim_slot_pktbuf.sv
module sim_slot_pktbuf;
  localparam int RXS = 2, TXS = 2, SB = 16, QD = 2, EW = 2;
  localparam int WPS = SB / 4;
  localparam int AW  = $clog2((RXS + TXS) * WPS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_last = 0, tx_ready = 1;
  logic [7:0] rx_data = 0;
  logic tx_valid, tx_last, irq;
  logic [7:0] tx_data;
  logic csr_we = 0, buf_we = 0;
  logic [7:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata, buf_wdata = 0, buf_rdata;
  logic [AW-1:0] buf_addr = 0;

  int checks = 0, errors = 0;
  int mode = 0;
  logic timeout = 0;
  logic [7:0] got [4096];
  int mon_cnt = 0, last_cnt = 0, last_idx = -1;

  always #5 clk = ~clk;

  slot_pktbuf #(.RX_SLOTS(RXS), .TX_SLOTS(TXS), .SLOT_BYTES(SB), .TXQ_DEPTH(QD), .ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .irq(irq));

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      got[mon_cnt] = tx_data;
      if (tx_last) begin
        last_cnt = last_cnt + 1;
        last_idx = mon_cnt;
      end
      mon_cnt = mon_cnt + 1;
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc = cyc + 1;
      tx_ready = (mode == 0) ? 1'b1 : (mode == 2) ? 1'b0 : ((cyc % 3) != 0);
    end
  end

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'((f * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic int mincap(input int n);
    return (n > SB) ? SB : n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 0;
  endtask

  task automatic csr_rd(input logic [7:0] a, output logic [31:0] d);
    csr_addr = a; #1;
    d = csr_rdata;
  endtask

  task automatic buf_wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    buf_we = 1; buf_addr = AW'(a); buf_wdata = d;
    @(posedge clk); #1;
    buf_we = 0;
  endtask

  task automatic buf_rd(input int a, output logic [31:0] d);
    buf_addr = AW'(a); #1;
    d = buf_rdata;
  endtask

  task automatic rx_frame(input int f, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1; rx_data = pat(f, i); rx_last = (i == n - 1);
    end
    @(posedge clk); #1;
    rx_valid = 0; rx_last = 0;
  endtask

  // Checks the presented receive frame and its stored bytes
  task automatic verify_rx(input string req, input int f, input int n, input int slot);
    logic [31:0] d, exp;
    int len;
    len = mincap(n);
    csr_rd(8'h10, d); chk({req, " pending"}, d, 1);
    csr_rd(8'h00, d); chk({req, " slot"}, d, slot);
    csr_rd(8'h04, d); chk({req, " length"}, d, len);
    for (int k = 0; k < (len + 3) / 4; k++) begin
      exp = 0;
      for (int j = 0; j < 4; j++)
        if (4 * k + j < len) exp[8*j +: 8] = pat(f, 4 * k + j);
      buf_rd(slot * WPS + k, d);
      chk({req, " rx data"}, d, exp);
    end
  endtask

  task automatic wait_tx_pend(output logic [31:0] d);
    d = 0;
    for (int t = 0; t < 300 && d == 0; t++) begin
      @(posedge clk); #1;
      csr_rd(8'h30, d);
    end
  endtask

  task automatic run_all();
    logic [31:0] d, w;
    int base, cnt0, n, slot;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    csr_rd(8'h10, d); chk("R1 rx pending", d, 0);
    csr_rd(8'h30, d); chk("R1 tx pending", d, 0);
    csr_rd(8'h1C, d); chk("R1 ready", d, 1);
    csr_rd(8'h20, d); chk("R1 level", d, 0);
    csr_rd(8'h08, d); chk("R1 drops", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);

    csr_wr(8'h14, 1);
    // R2 length sweep including lengths past the slot
    for (int L = 1; L <= SB + 4; L++) begin
      rx_frame(L, L);
      verify_rx("R2", L, L, 0);
      chk("R9 irq rx", irq, 1);
      csr_wr(8'h10, 1);
      csr_rd(8'h10, d); chk("R4 cleared", d, 0);
      chk("R9 irq off", irq, 0);
    end

    // R3 / R4 / R5 ordering, drop and clear
    rx_frame(50, 5);
    rx_frame(51, 9);
    verify_rx("R3 head A", 50, 5, 0);
    rx_frame(52, 3);
    csr_rd(8'h08, d); chk("R5 drop count", d, 1);
    verify_rx("R5 unchanged", 50, 5, 0);
    csr_wr(8'h10, 0);
    verify_rx("R4 write zero", 50, 5, 0);
    csr_wr(8'h10, 1);
    verify_rx("R3 queued B", 51, 9, 1);
    rx_frame(53, 4);
    csr_wr(8'h10, 1);
    verify_rx("R4 freed slot reused", 53, 4, 0);
    csr_wr(8'h10, 1);
    csr_rd(8'h10, d); chk("R4 drained", d, 0);

    // R5 saturation (2-bit counter: 1 + 4 drops -> 3)
    rx_frame(60, 2);
    rx_frame(61, 2);
    for (int q = 0; q < 4; q++) rx_frame(70 + q, 3);
    csr_rd(8'h08, d); chk("R5 saturate", d, 3);
    verify_rx("R5 after drops", 60, 2, 0);
    csr_wr(8'h10, 1);
    csr_wr(8'h10, 1);

    // R9 masked writer event
    csr_wr(8'h14, 0);
    rx_frame(80, 6);
    verify_rx("R9 masked", 80, 6, 0);
    chk("R9 masked irq", irq, 0);
    csr_wr(8'h10, 1);

    // R6 / R8 / R10 transmit sweep
    csr_wr(8'h34, 1);
    for (int L = 0; L <= SB + 2; L++) begin
      slot = L % 2;
      mode = (L % 3 == 1) ? 1 : 0;
      for (int k = 0; k < WPS; k++) begin
        for (int j = 0; j < 4; j++) w[8*j +: 8] = pat(100 + L, 4 * k + j);
        buf_wr(RXS * WPS + slot * WPS + k, w);
      end
      csr_rd(8'h1C, d); chk("R7 ready idle", d, 1);
      csr_wr(8'h24, slot);
      csr_wr(8'h28, L);
      csr_rd(8'h24, d); chk("R6 slot reg", d, slot);
      csr_rd(8'h28, d); chk("R6 len reg", d, L);
      base = mon_cnt; cnt0 = last_cnt;
      csr_wr(8'h18, 1);
      if (L == 5) begin
        csr_rd(8'h20, d); chk("R10 level queued", d, 1);
        @(posedge clk); #1;
        csr_rd(8'h20, d); chk("R10 level taken", d, 0);
      end
      wait_tx_pend(d);
      chk("R8 tx pending", d, 1);
      n = mincap(L);
      chk("R6 byte count", mon_cnt - base, n);
      for (int i = 0; i < n; i++) chk("R6 tx byte", got[base + i], pat(100 + L, i));
      chk("R6 last count", last_cnt - cnt0, (n > 0) ? 1 : 0);
      if (n > 0) chk("R6 last position", last_idx, base + n - 1);
      chk("R9 irq tx", irq, 1);
      csr_rd(8'h20, d); chk("R10 level done", d, 0);
      csr_wr(8'h30, 1);
      csr_rd(8'h30, d); chk("R8 cleared", d, 0);
      chk("R9 irq tx off", irq, 0);
    end

    // R7 start while busy is ignored
    mode = 2;
    csr_wr(8'h24, 0);
    csr_wr(8'h28, 8);
    base = mon_cnt;
    csr_wr(8'h18, 1);
    repeat (3) @(posedge clk); #1;
    csr_rd(8'h1C, d); chk("R7 ready busy", d, 0);
    csr_rd(8'h2C, d); chk("R7 status busy", d, 0);
    csr_wr(8'h18, 1);
    csr_rd(8'h20, d); chk("R7 ignored level", d, 0);
    mode = 0;
    wait_tx_pend(d);
    chk("R8 pending busy test", d, 1);
    repeat (40) @(posedge clk); #1;
    chk("R7 single frame", mon_cnt - base, 8);
    chk("R7 tx idle", tx_valid, 0);
    csr_wr(8'h30, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule